// File: doc/BRIEF.md
# Variable-Size Rotating Register Stack

This block is an integer register file of 128 architectural registers. Registers 0 to 31 are fixed. Register 0 always reads as zero. Registers 32 to 127 form a rotating window onto a circular array of 96 physical registers. The window starts at a frame base pointer, and its size is declared by software through an allocate command. The command gives a local count, which includes the incoming arguments, and an outgoing count.

A call command hides the caller's local set by advancing the base by the local count, modulo 96. The caller's first outgoing register then appears to the callee as register 32. A return command restores the caller's base and sizes from a small history stack.

The block tracks how many physical registers still hold the live locals of callers. When an allocate would need more registers than remain free, it raises an overflow flag and stalls. It waits until an external spill engine acknowledges that the older frames have been written out. The spill and fill engine itself lives outside this block.

The block has two combinational read ports and one synchronous write port. Each port flags an index that lies beyond the current frame.

Top module: `rse_regfile`

## Requirements
- R1: A write to fixed register 1..31 is read back unchanged on both read ports, whatever frame is active and whatever calls and returns happen in between.
- R2: Register 0 reads as zero on every port, and a write to it has no effect.
- R3: Rotating index 32+k addresses offset k of the current frame. If k is not below the frame size, the port's bad flag is high, the read data is zero and a write is dropped.
- R4: An accepted allocate of loc locals and out outgoing registers sets frame_loc to loc and frame_size to loc+out on the next cycle. A request with loc+out above 96 instead pulses cmd_err for one cycle and leaves the frame unchanged.
- R5: A call advances the base by frame_loc. On the next cycle frame_loc is 0 and frame_size is the caller's outgoing count. The caller's register 32+frame_loc is now seen as register 32.
- R6: A return restores the caller's base, frame_loc and frame_size, so that the caller sees its own registers, including any written by the callee through the shared outgoing area.
- R7: A return with an empty history pulses unf for one cycle and changes nothing. A call made while the history holds 16 entries pulses cmd_err and changes nothing.
- R8: An allocate whose size plus the registers held by callers' locals exceeds 96 raises ovf on the next cycle and leaves the frame unchanged. ovf stays high until spill_ack. On the cycle after spill_ack, ovf is low, the held allocate has taken effect, and the callers' count is cleared.
- R9: Physical addressing wraps modulo 96, so a frame that runs past the last physical register continues at physical register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 7 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_a_bad | output | 1 | Port A index beyond the current frame |
| rd_b_idx | input | 7 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| rd_b_bad | output | 1 | Port B index beyond the current frame |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Write register index |
| wr_data | input | 32 | Write data |
| wr_bad | output | 1 | Write index beyond the current frame (write dropped) |
| alloc_en | input | 1 | Allocate command |
| alloc_loc | input | 7 | Local-set size, including incoming registers |
| alloc_out | input | 7 | Outgoing-set size |
| call_en | input | 1 | Call command |
| ret_en | input | 1 | Return command |
| spill_ack | input | 1 | Spill of older frames complete |
| frame_loc | output | 7 | Current local-set size |
| frame_size | output | 7 | Current frame size (local plus outgoing) |
| ovf | output | 1 | Waiting for a spill; commands stalled |
| unf | output | 1 | One-cycle pulse: return with empty history |
| cmd_err | output | 1 | One-cycle pulse: oversize allocate or call with full history |

## Verification
The assertions assume that commands follow a fixed priority. Allocate wins over call, and call wins over return. Commands that arrive while ovf is high are ignored. spill_ack is only meaningful while ovf is high.

The stimulus issues one command at a time and drives every input on the falling clock edge. It never issues a command while the block is stalled. It raises spill_ack only after it has seen ovf high.

Because of this, the history and overflow properties see only well-formed command streams. The frame-size and physical-range checks, by contrast, hold for any input.

// File: rtl/rse_pkg.sv
// Package: shared constants and types for the rotating register stack.
// Assumes a 128-entry architectural space split into 32 fixed and 96 rotating registers.
package rse_pkg;
    localparam int NREG = 128;
    localparam int NFIX = 32;
    localparam int NROT = NREG - NFIX;
    localparam int IW   = $clog2(NREG);
    localparam int FW   = $clog2(NFIX);
    localparam int PW   = $clog2(NROT);
    localparam int CW   = $clog2(NROT + 1);

    // Result of translating one architectural index.
    typedef struct packed {
        logic          fixed;
        logic [FW-1:0] fidx;
        logic [PW-1:0] pidx;
        logic          bad;
    } map_t;
endpackage

// File: rtl/rse_map.sv
// Module: translates an architectural register index into a fixed index or a
// physical rotating index, relative to the frame base and size.
// Assumes base < NROT and fsize <= NROT.
module rse_map
    import rse_pkg::*;
(
    input  logic [IW-1:0] idx,
    input  logic [PW-1:0] base,
    input  logic [CW-1:0] fsize,
    output map_t          m
);
    logic [IW-1:0] off;
    logic [PW:0]   sum;

    // Frame offset and modulo-NROT physical address.
    always_comb begin
        m   = '0;
        off = idx - IW'(NFIX);
        sum = {1'b0, base} + (PW+1)'(off);
        if (idx < IW'(NFIX)) begin
            m.fixed = 1'b1;
            m.fidx  = idx[FW-1:0];
        end else if (CW'(off) >= fsize) begin
            m.bad = 1'b1;
        end else if (sum >= (PW+1)'(NROT)) begin
            m.pidx = PW'(sum - (PW+1)'(NROT));
        end else begin
            m.pidx = sum[PW-1:0];
        end
    end
endmodule

// File: rtl/rse_storage.sv
// Module: fixed and rotating register arrays with one write and two read ports.
// Assumes the caller never requests a write to fixed register 0 or through a bad map.
module rse_storage
    import rse_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  map_t          wmap,
    input  logic [DW-1:0] wdata,
    input  map_t          ramap,
    input  map_t          rbmap,
    output logic [DW-1:0] radata,
    output logic [DW-1:0] rbdata
);
    logic [DW-1:0] fix_q [NFIX];
    logic [DW-1:0] rot_q [NROT];

    // Synchronous write into the selected array.
    always_ff @(posedge clk) begin
        if (we) begin
            if (wmap.fixed) fix_q[wmap.fidx] <= wdata;
            else            rot_q[wmap.pidx] <= wdata;
        end
    end

    // Combinational read; register 0 and out-of-frame indices give zero.
    function automatic logic [DW-1:0] rd(input map_t m);
        if (m.fixed)    return (m.fidx == '0) ? '0 : fix_q[m.fidx];
        else if (m.bad) return '0;
        else            return rot_q[m.pidx];
    endfunction

    assign radata = rd(ramap);
    assign rbdata = rd(rbmap);
endmodule

// File: rtl/rse_frame_ctrl.sv
// Module: frame state machine: base pointer, frame sizes, call history,
// resident-register count and spill stall.
// Assumes at most one command per cycle (priority alloc, call, return);
// commands are ignored while a spill is pending.
module rse_frame_ctrl
    import rse_pkg::*;
#(
    parameter int HDEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [CW-1:0] alloc_loc,
    input  logic [CW-1:0] alloc_out,
    input  logic          call_en,
    input  logic          ret_en,
    input  logic          spill_ack,
    output logic [PW-1:0] base,
    output logic [CW-1:0] cur_loc,
    output logic [CW-1:0] cur_size,
    output logic          ovf,
    output logic          unf,
    output logic          cmd_err
);
    localparam int HW = $clog2(HDEPTH);
    localparam int DPW = $clog2(HDEPTH + 1);

    logic [CW-1:0]  loc_stk  [HDEPTH];
    logic [CW-1:0]  size_stk [HDEPTH];
    logic [DPW-1:0] depth;
    logic [CW-1:0]  dirty, pend_loc, pend_size;

    logic          do_alloc, do_call, do_ret, full, empty, size_bad, need_spill;
    logic [CW:0]   req_sum, adv;
    logic [CW-1:0] top_loc, top_size;
    logic [PW-1:0] base_back;
    logic [HW-1:0] top_ptr;

    // Command acceptance and derived frame arithmetic.
    always_comb begin
        do_alloc   = alloc_en && !ovf;
        do_call    = call_en && !ovf && !alloc_en;
        do_ret     = ret_en && !ovf && !alloc_en && !call_en;
        full       = depth == DPW'(HDEPTH);
        empty      = depth == '0;
        req_sum    = {1'b0, alloc_loc} + {1'b0, alloc_out};
        size_bad   = req_sum > (CW+1)'(NROT);
        need_spill = ({1'b0, dirty} + req_sum) > (CW+1)'(NROT);
        adv        = {1'b0, base} + {1'b0, cur_loc};
        if (adv >= (CW+1)'(NROT)) adv = adv - (CW+1)'(NROT);
        top_ptr    = HW'(depth - 1'b1);
        top_loc    = loc_stk[top_ptr];
        top_size   = size_stk[top_ptr];
        if (base >= PW'(top_loc)) base_back = base - PW'(top_loc);
        else                      base_back = PW'((CW+1)'(base) + (CW+1)'(NROT) - (CW+1)'(top_loc));
    end

    // History stack writes on an accepted call.
    always_ff @(posedge clk) begin
        if (do_call && !full) begin
            loc_stk[depth[HW-1:0]]  <= cur_loc;
            size_stk[depth[HW-1:0]] <= cur_size;
        end
    end

    // Frame registers, counters and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0; cur_loc <= '0; cur_size <= '0; depth <= '0; dirty <= '0;
            pend_loc <= '0; pend_size <= '0; ovf <= 1'b0; unf <= 1'b0; cmd_err <= 1'b0;
        end else begin
            unf     <= 1'b0;
            cmd_err <= 1'b0;
            if (ovf) begin
                if (spill_ack) begin
                    ovf      <= 1'b0;
                    dirty    <= '0;
                    cur_loc  <= pend_loc;
                    cur_size <= pend_size;
                end
            end else if (do_alloc) begin
                if (size_bad) begin
                    cmd_err <= 1'b1;
                end else if (need_spill) begin
                    ovf       <= 1'b1;
                    pend_loc  <= alloc_loc;
                    pend_size <= req_sum[CW-1:0];
                end else begin
                    cur_loc  <= alloc_loc;
                    cur_size <= req_sum[CW-1:0];
                end
            end else if (do_call) begin
                if (full) begin
                    cmd_err <= 1'b1;
                end else begin
                    depth    <= depth + 1'b1;
                    base     <= adv[PW-1:0];
                    dirty    <= dirty + cur_loc;
                    cur_loc  <= '0;
                    cur_size <= cur_size - cur_loc;
                end
            end else if (do_ret) begin
                if (empty) begin
                    unf <= 1'b1;
                end else begin
                    depth    <= depth - 1'b1;
                    base     <= base_back;
                    cur_loc  <= top_loc;
                    cur_size <= top_size;
                    dirty    <= (dirty >= top_loc) ? dirty - top_loc : '0;
                end
            end
        end
    end

    // R4
    size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_size <= CW'(NROT) && cur_loc <= cur_size);
    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !spill_ack |=> ovf && $stable(cur_size) && $stable(base));
    // R8
    ovf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && spill_ack |=> !ovf);
    // R7
    unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en && !ovf && !alloc_en && !call_en && depth == '0
        |=> unf && $stable(cur_size) && $stable(base));
    // R5
    call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_en && !ovf && !alloc_en && depth != DPW'(HDEPTH)
        |=> cur_loc == '0 && depth == $past(depth) + 1'b1);
endmodule

// File: rtl/rse_regfile.sv
// Module: top of the rotating register stack; joins index translation,
// storage and frame control.
// Assumes the spill engine outside acknowledges every raised ovf.
module rse_regfile
    import rse_pkg::*;
#(
    parameter int DW     = 32,
    parameter int HDEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_bad,
    input  logic [IW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_bad,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          wr_bad,
    input  logic          alloc_en,
    input  logic [CW-1:0] alloc_loc,
    input  logic [CW-1:0] alloc_out,
    input  logic          call_en,
    input  logic          ret_en,
    input  logic          spill_ack,
    output logic [CW-1:0] frame_loc,
    output logic [CW-1:0] frame_size,
    output logic          ovf,
    output logic          unf,
    output logic          cmd_err
);
    logic [PW-1:0] base;
    logic [IW-1:0] q_idx [3];
    map_t          q_map [3];
    logic          we;

    assign q_idx[0] = rd_a_idx;
    assign q_idx[1] = rd_b_idx;
    assign q_idx[2] = wr_idx;

    // One translator per port.
    for (genvar g = 0; g < 3; g++) begin : g_map
        rse_map u_map (.idx(q_idx[g]), .base(base), .fsize(frame_size), .m(q_map[g]));
        // R9
        phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !q_map[g].fixed && !q_map[g].bad |-> q_map[g].pidx < PW'(NROT));
    end

    // Gate writes to register 0 and to indices outside the frame.
    assign we = wr_en && !q_map[2].bad && !(q_map[2].fixed && q_map[2].fidx == '0);

    rse_storage #(.DW(DW)) u_store (
        .clk(clk), .we(we), .wmap(q_map[2]), .wdata(wr_data),
        .ramap(q_map[0]), .rbmap(q_map[1]), .radata(rd_a_data), .rbdata(rd_b_data)
    );

    rse_frame_ctrl #(.HDEPTH(HDEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_loc(alloc_loc),
        .alloc_out(alloc_out), .call_en(call_en), .ret_en(ret_en), .spill_ack(spill_ack),
        .base(base), .cur_loc(frame_loc), .cur_size(frame_size),
        .ovf(ovf), .unf(unf), .cmd_err(cmd_err)
    );

    assign rd_a_bad = q_map[0].bad;
    assign rd_b_bad = q_map[1].bad;
    assign wr_bad   = q_map[2].bad;

    // R3
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_bad |-> rd_a_data == '0);
    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx == '0 |-> rd_b_data == '0);
endmodule

// File: tb/tb_rse_regfile.sv
// Bench: table-driven write/read-back over one frame, then directed tests
// of reset, call, return, history limits, overflow stall and wrap.
module tb_rse_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        rd_a_bad, rd_b_bad, wr_bad, wr_en = 1'b0;
    logic        alloc_en = 1'b0, call_en = 1'b0, ret_en = 1'b0, spill_ack = 1'b0;
    logic [6:0]  alloc_loc = '0, alloc_out = '0, frame_loc, frame_size;
    logic        ovf, unf, cmd_err;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    rse_regfile dut (.*);

    // idx, write data, expected read, expected bad
    localparam logic [71:0] VEC [7] = '{
        {7'd1,   32'h0000_0011, 32'h0000_0011, 1'b0},
        {7'd0,   32'h0000_00FF, 32'h0000_0000, 1'b0},
        {7'd32,  32'h0000_00A0, 32'h0000_00A0, 1'b0},
        {7'd38,  32'h0000_00A6, 32'h0000_00A6, 1'b0},
        {7'd39,  32'h0000_0099, 32'h0000_0000, 1'b1},
        {7'd127, 32'h0000_0005, 32'h0000_0000, 1'b1},
        {7'd31,  32'h0000_0031, 32'h0000_0031, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] i);
        rd_a_idx = i; rd_b_idx = i;
        #1;
    endtask

    task automatic do_alloc(input logic [6:0] l, input logic [6:0] o);
        alloc_en = 1'b1; alloc_loc = l; alloc_out = o;
        tick();
        alloc_en = 1'b0;
    endtask

    task automatic do_call();
        call_en = 1'b1; tick(); call_en = 1'b0;
    endtask

    task automatic do_ret();
        ret_en = 1'b1; tick(); ret_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // Reset state
        check("R4 reset size", 32'(frame_size), 32'd0);
        check("R8 reset ovf", 32'(ovf), 32'd0);
        rd(7'd32);
        check("R3 reset bad", 32'(rd_a_bad), 32'd1);

        do_alloc(7'd4, 7'd3);
        check("R4 alloc loc", 32'(frame_loc), 32'd4);
        check("R4 alloc size", 32'(frame_size), 32'd7);

        // Table walk: R1 R2 R3
        for (int k = 0; k < 7; k++) begin
            wr(VEC[k][71:65], VEC[k][64:33]);
            rd(VEC[k][71:65]);
            check("R1/R2/R3 data A", rd_a_data, VEC[k][32:1]);
            check("R1/R2/R3 data B", rd_b_data, VEC[k][32:1]);
            check("R3 bad flag", 32'(rd_a_bad), 32'(VEC[k][0]));
        end

        // R5: call shifts outgoing to 32
        wr(7'd36, 32'hB4);
        do_call();
        check("R5 call loc", 32'(frame_loc), 32'd0);
        check("R5 call size", 32'(frame_size), 32'd3);
        rd(7'd32);
        check("R5 out to 32", rd_a_data, 32'hB4);
        rd(7'd35);
        check("R3 callee bad", 32'(rd_a_bad), 32'd1);
        rd(7'd1);
        check("R1 fixed after call", rd_a_data, 32'h11);

        // R6: callee writes shared area, return restores
        do_alloc(7'd2, 7'd2);
        wr(7'd33, 32'hC1);
        do_ret();
        check("R6 ret loc", 32'(frame_loc), 32'd4);
        check("R6 ret size", 32'(frame_size), 32'd7);
        rd(7'd37);
        check("R6 shared reg", rd_a_data, 32'hC1);
        rd(7'd32);
        check("R6 caller reg", rd_a_data, 32'hA0);

        // R7: return on empty history
        do_ret();
        check("R7 unf pulse", 32'(unf), 32'd1);
        check("R7 size kept", 32'(frame_size), 32'd7);
        tick();
        check("R7 unf one cycle", 32'(unf), 32'd0);

        // R4: oversize allocate
        do_alloc(7'd90, 7'd7);
        check("R4 err pulse", 32'(cmd_err), 32'd1);
        check("R4 size kept", 32'(frame_size), 32'd7);

        // R8: overflow stall
        do_alloc(7'd50, 7'd40);
        do_call();
        check("R5 call size 40", 32'(frame_size), 32'd40);
        do_alloc(7'd30, 7'd20);
        check("R8 ovf raised", 32'(ovf), 32'd1);
        check("R8 frame held", 32'(frame_size), 32'd40);
        tick(); tick();
        check("R8 ovf held", 32'(ovf), 32'd1);
        spill_ack = 1'b1; tick(); spill_ack = 1'b0;
        check("R8 ovf cleared", 32'(ovf), 32'd0);
        check("R8 alloc applied loc", 32'(frame_loc), 32'd30);
        check("R8 alloc applied size", 32'(frame_size), 32'd50);

        // R9: wrap across physical end
        do_call();
        do_alloc(7'd10, 7'd10);
        check("R8 no ovf after spill", 32'(ovf), 32'd0);
        wr(7'd47, 32'hE5);
        wr(7'd48, 32'hE6);
        do_ret();
        rd(7'd77);
        check("R9 last phys", rd_a_data, 32'hE5);
        rd(7'd78);
        check("R9 wrapped phys", rd_a_data, 32'hE6);
        do_ret();
        check("R6 outer size", 32'(frame_size), 32'd90);

        // R7: history full
        for (int k = 0; k < 16; k++) do_call();
        check("R7 no err at 16", 32'(cmd_err), 32'd0);
        do_call();
        check("R7 full err", 32'(cmd_err), 32'd1);
        check("R7 full size kept", 32'(frame_size), 32'd40);
        for (int k = 0; k < 16; k++) do_ret();
        check("R7 no unf at 16", 32'(unf), 32'd0);
        check("R6 unwound size", 32'(frame_size), 32'd90);
        do_ret();
        check("R7 unf after unwind", 32'(unf), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule